// File: doc/BRIEF.md
# Dual-Channel UART Host Register Front End

This block is the host-side register file of a two-channel UART. A host reaches it over an 8-bit parallel bus with three address lines, an active-low chip select and active-low read and write strobes. A channel-select input steers each access to channel A (`ch_sel` = 0) or channel B (`ch_sel` = 1). Each channel holds a 16-bit baud divisor (low and high byte), a line control byte whose bit 7 opens the divisor latch, an interrupt enable byte, a modem control byte, a scratch byte and an alternate function byte. The serial side is not built here. The receive byte, the line status, the baud clock and the receive-ready flag arrive as plain per-channel inputs. The divisor and a multifunction pin go out per channel.

The strobes may come from a host that shares no clock with the block. The combined "chip selected and write strobe low" condition passes through a synchronizer of `SYNC_STAGES` flops. Each new assertion of that condition commits one write from the address and data held on the bus. Reads are combinational and need no clock. When both divisor bytes of the addressed channel are zero, the divisor addresses return a device identifier and a revision code instead of the stored bytes. The read bus is a separate output that carries zero whenever no read is in progress.

Top module: `duart_host_regs`

## Requirements
- R1: A write commits when `cs_n` and `wr_n` are both low. It goes only to the channel chosen by `ch_sel` (0 = A, 1 = B), and the other channel's registers are unchanged.
- R2: A write strobe while `cs_n` is high changes no register.
- R3: `rd_data` carries the selected channel's addressed register while `cs_n` and `rd_n` are both low, and 0x00 at every other time.
- R4: Bit 7 of line control (address 3) is the latch-open bit. While it is 1, address 0 is the divisor low byte, address 1 is the divisor high byte and address 2 is the alternate function byte, for both reads and writes.
- R5: While the latch-open bit is 0:
  - address 0 reads the channel's `rx_byte` input and address 5 reads its `line_stat` input;
  - addresses 2 and 6 read 0x00;
  - address 1 is interrupt enable, address 4 is modem control and address 7 is scratch, all readable and writable;
  - writes to addresses 0, 2, 5 and 6 leave every register unchanged.
- R6: While the latch is open and both divisor bytes of the channel are 0x00, address 1 reads the identifier `DEV_ID` (default 0x0A) and address 0 reads `REV_ID` (default 0x01). If either byte is non-zero, both addresses read the stored bytes.
- R7: `divisor[c]` equals {high byte, low byte} of channel c.
- R8: `mf_n[c]` follows bits [1:0] of the channel's alternate function byte:
  - 00 gives the inverted modem control bit 3;
  - 01 gives the inverted `baud_clk[c]`;
  - 10 gives the inverted `rx_ready[c]`;
  - 11 drives 1.
- R9: `rst` high at a clock edge clears every register of both channels to 0x00. Afterwards divisors read 0, `mf_n` is 2'b11, and the identifier read works as soon as the latch is opened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock for strobe sampling and register storage |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ch_sel | input | 1 | Channel steer: 0 = A, 1 = B |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address within the channel |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data, zero when no read is in progress |
| rx_byte | input | 2x8 | Received byte per channel |
| line_stat | input | 2x8 | Line status byte per channel |
| baud_clk | input | 2 | Baud clock per channel |
| rx_ready | input | 2 | Receive-ready flag per channel |
| mf_n | output | 2 | Multifunction pin per channel, active low |
| divisor | output | 2x16 | Baud divisor per channel |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and the default identifier 0x0A and revision 0x01. The strobe therefore crosses a chain longer than the default. Bus cycles are held for several clocks to show that a write commits from stable bus values whatever the synchronizer depth. The default identifier values let the bench check the identifier readback against the codes named in the requirements. It also checks the change from identifier to stored byte when only one divisor byte is non-zero.

// File: rtl/duart_host_pkg.sv
package duart_host_pkg;
    localparam int NUM_CH   = 2;
    localparam int DW       = 8;
    localparam int AW       = 3;
    localparam int DIVW     = 2 * DW;
    localparam int LATCH_BIT = 7;
    localparam int OUT2_BIT  = 3;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [AW-1:0] {
        ADR_DATA  = 3'd0,
        ADR_IEN   = 3'd1,
        ADR_ALT   = 3'd2,
        ADR_LCTL  = 3'd3,
        ADR_MCTL  = 3'd4,
        ADR_LSTAT = 3'd5,
        ADR_MSTAT = 3'd6,
        ADR_SCR   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        MF_OUT2  = 2'b00,
        MF_BAUD  = 2'b01,
        MF_RXRDY = 2'b10,
        MF_RSVD  = 2'b11
    } mf_sel_e;

    typedef struct packed {
        byte_t div_lo;
        byte_t div_hi;
        byte_t ien;
        byte_t lctl;
        byte_t mctl;
        byte_t alt;
        byte_t scr;
    } chan_regs_t;

    localparam chan_regs_t CHAN_RESET = '0;

    function automatic logic latch_open(chan_regs_t r);
        return r.lctl[LATCH_BIT];
    endfunction

    function automatic logic divisor_blank(chan_regs_t r);
        return (r.div_lo == '0) && (r.div_hi == '0);
    endfunction
endpackage

// File: rtl/duart_strobe_sync.sv
module duart_strobe_sync
    #(parameter int STAGES = 2)
    (
    input  logic clk,
    input  logic rst,
    input  logic act,
    output logic commit
    );
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], act};
    end

    assign commit = chain_q[STAGES-1] & ~chain_q[STAGES];

    p_single_commit_r1: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
    import duart_host_pkg::*;
    #(parameter byte_t DEV_ID = 8'h0A,
      parameter byte_t REV_ID = 8'h01)
    (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  reg_addr_e  wr_addr,
    input  byte_t      wr_byte,
    input  reg_addr_e  rd_addr,
    input  byte_t      rx_byte,
    input  byte_t      line_stat,
    output byte_t      rdata,
    output chan_regs_t regs
    );
    logic dl_open;
    logic dl_blank;

    assign dl_open  = latch_open(regs);
    assign dl_blank = divisor_blank(regs);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= CHAN_RESET;
        end else if (we) begin
            case (wr_addr)
                ADR_DATA: if (dl_open) regs.div_lo <= wr_byte;
                ADR_IEN:  if (dl_open) regs.div_hi <= wr_byte;
                          else         regs.ien    <= wr_byte;
                ADR_ALT:  if (dl_open) regs.alt    <= wr_byte;
                ADR_LCTL: regs.lctl <= wr_byte;
                ADR_MCTL: regs.mctl <= wr_byte;
                ADR_SCR:  regs.scr  <= wr_byte;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (rd_addr)
            ADR_DATA:  rdata = dl_open ? (dl_blank ? REV_ID : regs.div_lo) : rx_byte;
            ADR_IEN:   rdata = dl_open ? (dl_blank ? DEV_ID : regs.div_hi) : regs.ien;
            ADR_ALT:   rdata = dl_open ? regs.alt : '0;
            ADR_LCTL:  rdata = regs.lctl;
            ADR_MCTL:  rdata = regs.mctl;
            ADR_LSTAT: rdata = line_stat;
            ADR_MSTAT: rdata = '0;
            ADR_SCR:   rdata = regs.scr;
            default:   rdata = '0;
        endcase
    end

    p_hold_without_write_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> (regs == $past(regs)));

    p_id_readback_r6: assert property (@(posedge clk) disable iff (rst)
        (regs.lctl[LATCH_BIT] && regs.div_lo == 8'h00 && regs.div_hi == 8'h00
         && rd_addr == ADR_IEN) |-> (rdata == DEV_ID));
endmodule

// File: rtl/duart_mf_pin.sv
module duart_mf_pin
    import duart_host_pkg::*;
    (
    input  mf_sel_e sel,
    input  logic    out2,
    input  logic    baud_clk,
    input  logic    rx_ready,
    output logic    mf_n
    );
    always_comb begin
        case (sel)
            MF_OUT2:  mf_n = ~out2;
            MF_BAUD:  mf_n = ~baud_clk;
            MF_RXRDY: mf_n = ~rx_ready;
            default:  mf_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/duart_host_regs.sv
module duart_host_regs
    import duart_host_pkg::*;
    #(parameter int    SYNC_STAGES = 2,
      parameter byte_t DEV_ID      = 8'h0A,
      parameter byte_t REV_ID      = 8'h01)
    (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_n,
    input  logic                      ch_sel,
    input  logic                      rd_n,
    input  logic                      wr_n,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wr_data,
    output logic [DW-1:0]             rd_data,
    input  logic [NUM_CH-1:0][DW-1:0] rx_byte,
    input  logic [NUM_CH-1:0][DW-1:0] line_stat,
    input  logic [NUM_CH-1:0]         baud_clk,
    input  logic [NUM_CH-1:0]         rx_ready,
    output logic [NUM_CH-1:0]         mf_n,
    output logic [NUM_CH-1:0][DIVW-1:0] divisor
    );
    logic       commit;
    logic       reading;
    reg_addr_e  bus_addr;
    byte_t      ch_rdata [NUM_CH];
    chan_regs_t ch_regs  [NUM_CH];

    assign bus_addr = reg_addr_e'(addr);
    assign reading  = ~cs_n & ~rd_n;

    duart_strobe_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk    (clk),
        .rst    (rst),
        .act    (~cs_n & ~wr_n),
        .commit (commit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        duart_chan_regs #(.DEV_ID(DEV_ID), .REV_ID(REV_ID)) u_regs (
            .clk       (clk),
            .rst       (rst),
            .we        (commit && (ch_sel == c[0])),
            .wr_addr   (bus_addr),
            .wr_byte   (wr_data),
            .rd_addr   (bus_addr),
            .rx_byte   (rx_byte[c]),
            .line_stat (line_stat[c]),
            .rdata     (ch_rdata[c]),
            .regs      (ch_regs[c])
        );

        duart_mf_pin u_mf (
            .sel      (mf_sel_e'(ch_regs[c].alt[1:0])),
            .out2     (ch_regs[c].mctl[OUT2_BIT]),
            .baud_clk (baud_clk[c]),
            .rx_ready (rx_ready[c]),
            .mf_n     (mf_n[c])
        );

        assign divisor[c] = {ch_regs[c].div_hi, ch_regs[c].div_lo};

        p_mf_reserved_r8: assert property (@(posedge clk) disable iff (rst)
            (ch_regs[c].alt[1:0] == 2'b11) |-> mf_n[c]);
    end

    assign rd_data = reading ? ch_rdata[ch_sel] : '0;

    p_bus_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (rd_data == 8'h00));

    p_other_chan_r1: assert property (@(posedge clk) disable iff (rst)
        (commit && !ch_sel) |=> $stable(ch_regs[1]));
endmodule

// File: tb/duart_host_regs_test.sv
`timescale 1ns/1ps
module duart_host_regs_test;
    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cs_n = 1'b1, ch_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0]       addr = '0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       rd_data;
    logic [1:0][7:0]  rx_byte = {8'h3C, 8'hA5};
    logic [1:0][7:0]  line_stat = {8'h21, 8'h60};
    logic [1:0]       baud_clk = '0;
    logic [1:0]       rx_ready = '0;
    logic [1:0]       mf_n;
    logic [1:0][15:0] divisor;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    duart_host_regs #(.SYNC_STAGES(3)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ch_sel(ch_sel), .rd_n(rd_n),
        .wr_n(wr_n), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .rx_byte(rx_byte), .line_stat(line_stat), .baud_clk(baud_clk),
        .rx_ready(rx_ready), .mf_n(mf_n), .divisor(divisor)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic ch, logic [2:0] a, logic [7:0] d, logic sel_n = 1'b0);
        @(negedge clk);
        ch_sel = ch; addr = a; wr_data = d; cs_n = sel_n; wr_n = 1'b0;
        idle(8);
        wr_n = 1'b1; cs_n = 1'b1;
        idle(6);
    endtask

    task automatic bus_read(logic ch, logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        ch_sel = ch; addr = a; cs_n = 1'b0; rd_n = 1'b0;
        #1 d = rd_data;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic read_check(string req, logic ch, logic [2:0] a, logic [7:0] exp);
        logic [7:0] d;
        bus_read(ch, a, d);
        check(req, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic t_reset();
        #1;
        check("R9 divisor A after reset", divisor[0], 16'h0);
        check("R9 divisor B after reset", divisor[1], 16'h0);
        check("R9 mf_n after reset", mf_n, 2'b11);
        read_check("R9 line control A after reset", 1'b0, 3'd3, 8'h00);
        read_check("R9 scratch B after reset", 1'b1, 3'd7, 8'h00);
    endtask

    task automatic t_ident();
        bus_write(1'b0, 3'd3, 8'h80);
        read_check("R6 identifier", 1'b0, 3'd1, 8'h0A);
        read_check("R6 revision", 1'b0, 3'd0, 8'h01);
    endtask

    task automatic t_latch();
        bus_write(1'b0, 3'd0, 8'h34);
        bus_write(1'b0, 3'd1, 8'h12);
        read_check("R4 divisor low", 1'b0, 3'd0, 8'h34);
        read_check("R4 divisor high", 1'b0, 3'd1, 8'h12);
        #1;
        check("R7 divisor A", divisor[0], 16'h1234);
        check("R1 divisor B untouched", divisor[1], 16'h0);
        bus_write(1'b0, 3'd0, 8'h00);
        read_check("R6 low zero only reads stored", 1'b0, 3'd0, 8'h00);
        read_check("R6 high non-zero reads stored", 1'b0, 3'd1, 8'h12);
        bus_write(1'b0, 3'd1, 8'h00);
        read_check("R6 identifier again", 1'b0, 3'd1, 8'h0A);
        bus_write(1'b0, 3'd2, 8'h02);
        read_check("R4 alternate function", 1'b0, 3'd2, 8'h02);
    endtask

    task automatic t_normal_map();
        bus_write(1'b0, 3'd3, 8'h03);
        read_check("R5 rx byte A", 1'b0, 3'd0, 8'hA5);
        read_check("R5 line status A", 1'b0, 3'd5, 8'h60);
        read_check("R5 line status B", 1'b1, 3'd5, 8'h21);
        bus_write(1'b0, 3'd1, 8'h0F);
        read_check("R5 interrupt enable", 1'b0, 3'd1, 8'h0F);
        bus_write(1'b0, 3'd0, 8'h77);
        bus_write(1'b0, 3'd2, 8'h03);
        bus_write(1'b0, 3'd6, 8'h55);
        #1;
        check("R5 divisor kept", divisor[0], 16'h0);
        read_check("R5 address 2 reads zero", 1'b0, 3'd2, 8'h00);
        read_check("R5 address 6 reads zero", 1'b0, 3'd6, 8'h00);
        read_check("R5 line control", 1'b0, 3'd3, 8'h03);
        bus_write(1'b0, 3'd3, 8'h80);
        read_check("R5 alt not written while closed", 1'b0, 3'd2, 8'h02);
        bus_write(1'b0, 3'd3, 8'h03);
    endtask

    task automatic t_channels();
        bus_write(1'b1, 3'd7, 8'h5A);
        read_check("R1 scratch B", 1'b1, 3'd7, 8'h5A);
        read_check("R1 scratch A untouched", 1'b0, 3'd7, 8'h00);
        bus_write(1'b0, 3'd7, 8'hC3, 1'b1);
        read_check("R2 write without select", 1'b0, 3'd7, 8'h00);
    endtask

    task automatic t_bus_idle();
        @(negedge clk);
        ch_sel = 1'b1; addr = 3'd7; cs_n = 1'b1; rd_n = 1'b0;
        #1 check("R3 no select reads zero", rd_data, 8'h00);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b1;
        #1 check("R3 no strobe reads zero", rd_data, 8'h00);
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic t_mf();
        rx_ready[0] = 1'b1;
        #1 check("R8 receive ready low", mf_n[0], 1'b0);
        rx_ready[0] = 1'b0;
        #1 check("R8 receive ready idle", mf_n[0], 1'b1);
        bus_write(1'b0, 3'd3, 8'h80);
        bus_write(1'b0, 3'd2, 8'h01);
        baud_clk[0] = 1'b1;
        #1 check("R8 baud clock", mf_n[0], 1'b0);
        bus_write(1'b0, 3'd2, 8'h00);
        bus_write(1'b0, 3'd4, 8'h08);
        #1 check("R8 out2 set", mf_n[0], 1'b0);
        bus_write(1'b0, 3'd4, 8'h00);
        #1 check("R8 out2 clear", mf_n[0], 1'b1);
        bus_write(1'b0, 3'd4, 8'h08);
        bus_write(1'b0, 3'd2, 8'h03);
        rx_ready[0] = 1'b1;
        #1 check("R8 reserved inactive", mf_n[0], 1'b1);
        check("R8 channel B idle", mf_n[1], 1'b1);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        #1;
        check("R9 mf_n after second reset", mf_n, 2'b11);
        read_check("R9 scratch B cleared", 1'b1, 3'd7, 8'h00);
        bus_write(1'b1, 3'd3, 8'h80);
        read_check("R9 identifier after reset", 1'b1, 3'd1, 8'h0A);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_ident();
        t_latch();
        t_normal_map();
        t_channels();
        t_bus_idle();
        t_mf();
        t_mid_reset();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule